// File: doc/BRIEF.md
# Per-Line Input Glitch and Debounce Filter Bank

This block sits between a bank of input pads and the port's readback path. Each line is first passed through a two-flop synchroniser. It then goes through a filter that can be switched off or set to one of two modes, chosen separately for every line. In glitch mode, a new level must be seen on two main-clock edges in a row before it reaches the output. In debounce mode, a new level must be seen on two slow ticks in a row. Those ticks come from one divider shared by the whole bank, and its ratio is set by a register.

Whether a line is filtered, and in which mode, is held in two status words. Each word changes only through its own pair of write-one strobes: one strobe sets bits and the other clears them. The output of every line is registered. The divide value is loaded through a write strobe, and each load restarts the tick counter.

Top module: `line_filter_bank`

## Requirements
- R1: After reset, `en_stat` and `mode_stat` are all zero and `line_out` is all zero.
- R2: A one on `en_set`/`mode_set` sets the matching status bit and a one on `en_clr`/`mode_clr` clears it, visible one clock later. A bit that is both set and cleared in the same cycle ends up set. Bits with no strobe keep their value.
- R3: With filtering disabled (`en_stat` bit 0), a pad level reaches `line_out` on the third rising clock edge after it is applied. A pulse lasting a single clock passes through.
- R4: With filtering enabled and mode bit 0 (glitch mode), a level reaches `line_out` on the fourth rising edge. A pulse lasting one clock never appears, and a pulse of two clocks or more does.
- R5: With filtering enabled and mode bit 1 (debounce mode), the output takes a new level only on a tick, and only when that level was also present on the previous tick. With divide value d, a tick falls every d+1 clocks. A pulse of d+1 clocks or fewer is always removed, and one of 2(d+1) clocks or more always passes.
- R6: The divide value resets to 3 and is replaced by `div_val` when `div_wr` is high, which also restarts the tick count.
- R7: Each line's mode applies to that line alone. A pulse presented to several lines is filtered per line.
- R8: When filtering is disabled, the mode bit has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | LINES | Raw pad levels |
| en_set | input | LINES | Write-one strobe: enable filtering |
| en_clr | input | LINES | Write-one strobe: disable filtering |
| mode_set | input | LINES | Write-one strobe: select debounce mode |
| mode_clr | input | LINES | Write-one strobe: select glitch mode |
| div_wr | input | 1 | Load strobe for the divide value |
| div_val | input | DIV_W | New divide value d (tick every d+1 clocks) |
| en_stat | output | LINES | Filter-enable status |
| mode_stat | output | LINES | Mode status (1 = debounce) |
| line_out | output | LINES | Filtered line levels |

## Verification
The bench measures latency to the exact edge in bypass and glitch modes. A design with a missing or extra synchroniser stage, or a glitch filter that compares against the wrong sample, moves the output by one cycle and is caught. Debounce pulses are sent just under and just over the bounds for several divide values, including a divide value of zero. This exposes a design that checks only one tick, miscounts the tick period, or ignores a divide write. Further tests give a simultaneous set and clear to one status bit, set the mode bit on a line whose filtering is disabled, and send one pulse across lines in different modes. These catch the wrong strobe priority, a mode leaking into bypass, and state shared between lines.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

  typedef enum logic [1:0] {
    FM_PASS     = 2'd0,
    FM_GLITCH   = 2'd1,
    FM_DEBOUNCE = 2'd2
  } filt_mode_e;

  // Effective filter mode of one line from its two status bits.
  function automatic filt_mode_e pick_mode(input logic en, input logic sel);
    if (!en) return FM_PASS;
    return sel ? FM_DEBOUNCE : FM_GLITCH;
  endfunction

  // A new level is accepted when the current sample matches the stored one.
  function automatic logic accept(input logic cur, input logic held);
    return cur == held;
  endfunction

endpackage

// File: rtl/lfb_mask.sv
module lfb_mask #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  // Set takes priority over clear on the same bit.
  function automatic logic [W-1:0] mask_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] s,
                                             input logic [W-1:0] c);
    return (cur & ~c) | s;
  endfunction

  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= mask_next(stat_q, set_i, clr_i);
  end

  assign stat_o = stat_q;

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  // R2
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == '0) |=> $stable(stat_o));

endmodule

// File: rtl/lfb_divider.sv
module lfb_divider #(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] val_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             hit_w;

  assign hit_w  = (cnt_q == div_q);
  assign tick_o = hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      cnt_q <= '0;
    end else if (wr_i) begin
      div_q <= val_i;
      cnt_q <= '0;
    end else if (hit_w) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !wr_i && div_q != '0) |=> !tick_o);

  // R6
  div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (div_q == $past(val_i) && cnt_q == '0));

endmodule

// File: rtl/lfb_line.sv
module lfb_line
  import lfb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  input  logic en_i,
  input  logic mode_i,
  input  logic tick_i,
  output logic out_o
);

  logic       s1_q, s2_q;
  logic       prev_g_q;
  logic       prev_d_q;
  logic       out_q;
  filt_mode_e mode_w;

  assign mode_w = pick_mode(en_i, mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      prev_g_q <= 1'b0;
      prev_d_q <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      s1_q     <= pad_i;
      s2_q     <= s1_q;
      prev_g_q <= s2_q;
      if (tick_i) prev_d_q <= s2_q;
      case (mode_w)
        FM_PASS:     out_q <= s2_q;
        FM_GLITCH:   if (accept(s2_q, prev_g_q)) out_q <= s2_q;
        FM_DEBOUNCE: if (tick_i && accept(s2_q, prev_d_q)) out_q <= s2_q;
        default:     out_q <= out_q;
      endcase
    end
  end

  assign out_o = out_q;

  // R4
  glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == FM_GLITCH && s2_q != prev_g_q) |=> $stable(out_q));

  // R5
  debounce_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == FM_DEBOUNCE && !tick_i) |=> $stable(out_q));

  // R5
  debounce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == FM_DEBOUNCE && s2_q != prev_d_q) |=> $stable(out_q));

endmodule

// File: rtl/line_filter_bank.sv
module line_filter_bank #(
  parameter int               LINES   = 8,
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  input  logic [LINES-1:0] en_set,
  input  logic [LINES-1:0] en_clr,
  input  logic [LINES-1:0] mode_set,
  input  logic [LINES-1:0] mode_clr,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic [LINES-1:0] en_stat,
  output logic [LINES-1:0] mode_stat,
  output logic [LINES-1:0] line_out
);

  logic slow_tick;

  lfb_mask #(.W(LINES)) i_en_mask (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .stat_o(en_stat)
  );

  lfb_mask #(.W(LINES)) i_mode_mask (
    .clk(clk), .rst_n(rst_n), .set_i(mode_set), .clr_i(mode_clr), .stat_o(mode_stat)
  );

  lfb_divider #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_div (
    .clk(clk), .rst_n(rst_n), .wr_i(div_wr), .val_i(div_val), .tick_o(slow_tick)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lfb_line i_line (
      .clk(clk),
      .rst_n(rst_n),
      .pad_i(pad_in[g]),
      .en_i(en_stat[g]),
      .mode_i(mode_stat[g]),
      .tick_i(slow_tick),
      .out_o(line_out[g])
    );
  end

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (en_stat == '0 && mode_stat == '0));

endmodule

// File: tb/test_line_filter_bank.sv
`timescale 1ns/1ps
module test_line_filter_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pad_in = '0, en_set = '0, en_clr = '0, mode_set = '0, mode_clr = '0;
  logic       div_wr = 1'b0;
  logic [7:0] div_val = '0;
  logic [7:0] en_stat, mode_stat, line_out;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  line_filter_bank i_line_filter_bank (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .en_set(en_set), .en_clr(en_clr), .mode_set(mode_set), .mode_clr(mode_clr),
    .div_wr(div_wr), .div_val(div_val),
    .en_stat(en_stat), .mode_stat(mode_stat), .line_out(line_out)
  );

  // Vector: [15:14] mode (0 bypass, 1 glitch, 2 debounce), [13:8] divide, [7:1] pulse length, [0] pulse seen
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 6'd3, 7'd1,  1'b1},  // R3
    {2'd1, 6'd3, 7'd1,  1'b0},  // R4
    {2'd1, 6'd3, 7'd2,  1'b1},  // R4
    {2'd1, 6'd3, 7'd5,  1'b1},  // R4
    {2'd2, 6'd3, 7'd4,  1'b0},  // R5
    {2'd2, 6'd3, 7'd8,  1'b1},  // R5
    {2'd2, 6'd0, 7'd1,  1'b0},  // R5 R6
    {2'd2, 6'd0, 7'd2,  1'b1},  // R5 R6
    {2'd2, 6'd7, 7'd8,  1'b0},  // R5 R6
    {2'd2, 6'd7, 7'd16, 1'b1}   // R5 R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] es, input logic [7:0] ec, input logic [7:0] ms,
                     input logic [7:0] mc, input logic dw, input logic [7:0] dv);
    @(negedge clk);
    en_set = es; en_clr = ec; mode_set = ms; mode_clr = mc; div_wr = dw; div_val = dv;
    @(negedge clk);
    en_set = '0; en_clr = '0; mode_set = '0; mode_clr = '0; div_wr = 1'b0;
  endtask

  // Quiet low, pulse the given lines high for len clocks, record which outputs went high.
  task automatic pulse(input logic [7:0] lines, input int len, output logic [7:0] seen);
    pad_in = '0;
    repeat (40) @(negedge clk);
    seen = '0;
    pad_in = lines;
    for (int i = 0; i < len + 40; i++) begin
      @(negedge clk);
      if (i == len - 1) pad_in = '0;
      seen |= line_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 en_stat", en_stat, 8'h00);
    check("R1 mode_stat", mode_stat, 8'h00);
    check("R1 line_out", line_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 default divide value 3: 4-clock pulse removed, 8-clock pulse kept
    cfg(8'h08, 8'h00, 8'h08, 8'h00, 1'b0, 8'h00);
    pulse(8'h08, 4, seen);
    check("R6 default div short", seen[3], 1'b0);
    pulse(8'h08, 8, seen);
    check("R6 default div long", seen[3], 1'b1);
    cfg(8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0, 8'h00);

    // R2 set/clear strobes and priority
    cfg(8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    check("R2 set", en_stat, 8'h0F);
    check("R2 mode untouched", mode_stat, 8'h00);
    cfg(8'h01, 8'h03, 8'h00, 8'h00, 1'b0, 8'h00);
    check("R2 set wins / clear", en_stat, 8'h0D);
    cfg(8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 8'h00);
    check("R2 clear all", en_stat, 8'h00);

    // Vector table on line 0
    for (int v = 0; v < NV; v++) begin
      logic [1:0] md;
      md = VEC[v][15:14];
      cfg((md != 2'd0) ? 8'h01 : 8'h00, (md == 2'd0) ? 8'h01 : 8'h00,
          (md == 2'd2) ? 8'h01 : 8'h00, (md != 2'd2) ? 8'h01 : 8'h00,
          1'b1, {2'b00, VEC[v][13:8]});
      pulse(8'h01, int'(VEC[v][7:1]), seen);
      check($sformatf("R3/R4/R5 vector %0d", v), seen[0], VEC[v][0]);
    end
    cfg(8'h00, 8'hFF, 8'h00, 8'hFF, 1'b1, 8'd3);
    repeat (40) @(negedge clk);

    // R3 bypass latency: third rising edge
    pad_in = 8'h02;
    repeat (2) @(negedge clk);
    check("R3 latency early", line_out[1], 1'b0);
    @(negedge clk);
    check("R3 latency", line_out[1], 1'b1);
    pad_in = '0;
    repeat (10) @(negedge clk);

    // R4 glitch latency: fourth rising edge
    cfg(8'h02, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    pad_in = 8'h02;
    repeat (3) @(negedge clk);
    check("R4 latency early", line_out[1], 1'b0);
    @(negedge clk);
    check("R4 latency", line_out[1], 1'b1);
    pad_in = '0;
    repeat (10) @(negedge clk);

    // R8 mode bit set on disabled line: still bypass timing
    cfg(8'h00, 8'h00, 8'h04, 8'h00, 1'b0, 8'h00);
    pad_in = 8'h04;
    repeat (2) @(negedge clk);
    check("R8 early", line_out[2], 1'b0);
    @(negedge clk);
    check("R8 bypass with mode bit", line_out[2], 1'b1);
    pad_in = '0;
    repeat (10) @(negedge clk);

    // R7 per-line independence: line1 glitch, line5 bypass, line6 debounce
    cfg(8'h40, 8'h20, 8'h40, 8'h02, 1'b0, 8'h00);
    pulse(8'h62, 1, seen);
    check("R7 glitch line drops", seen[1], 1'b0);
    check("R7 bypass line passes", seen[5], 1'b1);
    check("R7 debounce line drops", seen[6], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule